// File: doc/BRIEF.md
# Serial Gray/Binary Stream Converter

This block converts bit-serial words between reflected Gray code and plain binary, one bit per clock, most significant bit first. It has two channels that share only the clock and reset. The decode channel takes a Gray stream and returns the matching binary stream. The encode channel takes a binary stream and returns the matching Gray stream.

Each channel holds one bit of state, kept as a two-state enumerated machine. The decode channel tracks the running parity of the Gray bits it has seen, in the states `PAR_EVEN` and `PAR_ODD`. Each valid Gray 1 is a "toggle" transition and each valid Gray 0 is a "hold" transition. The encode channel remembers the last binary bit, in the states `PREV_LOW` and `PREV_HIGH`. Each valid bit is a "load" transition into the state named by its value.

A start-of-word strobe, given with a word's MSB, makes the machine act as if it were in its cleared state (`PAR_EVEN` or `PREV_LOW`) for that bit. The MSB therefore passes through unchanged. When the valid qualifier is low, the machine does not move. Every output bit is registered, so it leaves one clock after its input bit, and the output valid is delayed to match. Because the output comes straight from a flop, logic that decodes it sees no glitches.

Top module: `serial_gray_codec`

## Requirements
- R1: While reset is high at a clock edge, both output valids and both output bits become 0 and both machines go to their cleared states.
- R2: Each output valid equals its channel's input valid one clock earlier.
- R3: Decode channel: when input valid and start are both high, the binary bit output one clock later equals the Gray input bit.
- R4: Decode channel: for a valid bit without start, the output one clock later is the previous output XOR the Gray input bit. Binary bit j is therefore the XOR of the word's Gray bits from the MSB down to bit j.
- R5: Encode channel: when input valid and start are both high, the Gray bit output one clock later equals the binary input bit.
- R6: Encode channel: for a valid bit without start, the output one clock later is the binary input bit XOR the previous valid binary bit.
- R7: A cycle with input valid low changes neither the channel's state nor its output bit, and drives its output valid low. This holds even when the start strobe and the data bit are high in that cycle. Such idle cycles may fall between the bits of a word.
- R8: The two channels are independent: activity on one never changes the output bit or output valid of the other.
- R9: Words may follow each other with no idle cycle: a start strobe on the cycle right after a word's LSB begins a correct new word.
- R10: Gray 1001011 decodes to binary 1110010, and binary 1110010 encodes to Gray 1001011 (7-bit words, MSB first).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gray_in_bit | input | 1 | Decode channel serial Gray data |
| gray_in_vld | input | 1 | Decode channel input qualifier |
| gray_in_sow | input | 1 | Decode channel start of word, given with the MSB |
| bin_out_bit | output | 1 | Decode channel serial binary result, registered |
| bin_out_vld | output | 1 | Decode channel output qualifier |
| bin_in_bit | input | 1 | Encode channel serial binary data |
| bin_in_vld | input | 1 | Encode channel input qualifier |
| bin_in_sow | input | 1 | Encode channel start of word, given with the MSB |
| gray_out_bit | output | 1 | Encode channel serial Gray result, registered |
| gray_out_vld | output | 1 | Encode channel output qualifier |

## Verification
The assertions assume reset is high from time zero and that the start strobe comes with each word's first bit, so every word begins from a cleared machine. The encode-channel check also assumes the bit before a non-start valid bit belongs to the same word. The stimulus follows these rules. Every word the bench sends starts with a strobe on its MSB. Idle cycles inside a word always have the valid qualifier low, even when they carry a high strobe and a high data bit.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    // Decode channel: running parity of the Gray bits seen so far in a word
    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_e;

    // Encode channel: last binary bit seen in the current word
    typedef enum logic {
        PREV_LOW  = 1'b0,
        PREV_HIGH = 1'b1
    } prev_e;

    // One serial lane as it enters a channel
    typedef struct packed {
        logic dat;
        logic vld;
        logic sow;
    } lane_t;

endpackage

// File: rtl/sgc_g2b_chan.sv
module sgc_g2b_chan
    import sgc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane,
    output logic  out_bit,
    output logic  out_vld
);

    par_e cur_st;
    par_e base_st;
    par_e nxt_st;

    // the start strobe makes this bit act on a cleared parity
    always_comb begin
        base_st = lane.sow ? PAR_EVEN : cur_st;
        nxt_st  = cur_st;
        if (lane.vld) begin
            unique case (base_st)
                PAR_EVEN: nxt_st = lane.dat ? PAR_ODD  : PAR_EVEN;
                PAR_ODD:  nxt_st = lane.dat ? PAR_EVEN : PAR_ODD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) cur_st <= PAR_EVEN;
        else     cur_st <= nxt_st;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= lane.vld;
            if (lane.vld) out_bit <= (nxt_st == PAR_ODD);
        end
    end

endmodule

// File: rtl/sgc_b2g_chan.sv
module sgc_b2g_chan
    import sgc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane,
    output logic  out_bit,
    output logic  out_vld
);

    prev_e cur_st;
    prev_e base_st;
    prev_e nxt_st;
    logic  gray_c;

    // load transition: the state follows each valid binary bit
    always_comb begin
        base_st = lane.sow ? PREV_LOW : cur_st;
        nxt_st  = cur_st;
        if (lane.vld) nxt_st = lane.dat ? PREV_HIGH : PREV_LOW;
    end

    // Gray bit = this binary bit XOR the one before it in the word
    always_comb begin
        unique case (base_st)
            PREV_LOW:  gray_c = lane.dat;
            PREV_HIGH: gray_c = ~lane.dat;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) cur_st <= PREV_LOW;
        else     cur_st <= nxt_st;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= lane.vld;
            if (lane.vld) out_bit <= gray_c;
        end
    end

endmodule

// File: rtl/serial_gray_codec.sv
module serial_gray_codec
    import sgc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gray_in_bit,
    input  logic gray_in_vld,
    input  logic gray_in_sow,
    output logic bin_out_bit,
    output logic bin_out_vld,
    input  logic bin_in_bit,
    input  logic bin_in_vld,
    input  logic bin_in_sow,
    output logic gray_out_bit,
    output logic gray_out_vld
);

    lane_t dec_lane;
    lane_t enc_lane;

    assign dec_lane = '{dat: gray_in_bit, vld: gray_in_vld, sow: gray_in_sow};
    assign enc_lane = '{dat: bin_in_bit,  vld: bin_in_vld,  sow: bin_in_sow};

    sgc_g2b_chan i_dec (
        .clk     (clk),
        .rst     (rst),
        .lane    (dec_lane),
        .out_bit (bin_out_bit),
        .out_vld (bin_out_vld)
    );

    sgc_b2g_chan i_enc (
        .clk     (clk),
        .rst     (rst),
        .lane    (enc_lane),
        .out_bit (gray_out_bit),
        .out_vld (gray_out_vld)
    );

endmodule

// File: rtl/sgc_checker.sv
module sgc_checker (
    input logic clk,
    input logic rst,
    input logic gray_in_bit,
    input logic gray_in_vld,
    input logic gray_in_sow,
    input logic bin_out_bit,
    input logic bin_out_vld,
    input logic bin_in_bit,
    input logic bin_in_vld,
    input logic bin_in_sow,
    input logic gray_out_bit,
    input logic gray_out_vld
);

    // cycles since reset release, saturating, gates two-deep history
    logic [1:0] up_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 up_cnt <= 2'd0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bin_out_vld && !gray_out_vld && !bin_out_bit && !gray_out_bit));

    // R2
    dec_vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        gray_in_vld |=> bin_out_vld);

    // R2
    enc_vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        bin_in_vld |=> gray_out_vld);

    // R3
    dec_msb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (gray_in_vld && gray_in_sow) |=> (bin_out_bit == $past(gray_in_bit)));

    // R4
    dec_accum_chk: assert property (@(posedge clk) disable iff (rst)
        (gray_in_vld && !gray_in_sow) |=> (bin_out_bit == ($past(bin_out_bit) ^ $past(gray_in_bit))));

    // R5
    enc_msb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (bin_in_vld && bin_in_sow) |=> (gray_out_bit == $past(bin_in_bit)));

    // R6
    enc_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cnt == 2'd3 && bin_in_vld && !bin_in_sow && $past(bin_in_vld))
        |=> (gray_out_bit == ($past(bin_in_bit) ^ $past(bin_in_bit, 2))));

    // R7
    dec_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gray_in_vld |=> (!bin_out_vld && $stable(bin_out_bit)));

    // R7
    enc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bin_in_vld |=> (!gray_out_vld && $stable(gray_out_bit)));

endmodule

bind serial_gray_codec sgc_checker i_sgc_checker (
    .clk          (clk),
    .rst          (rst),
    .gray_in_bit  (gray_in_bit),
    .gray_in_vld  (gray_in_vld),
    .gray_in_sow  (gray_in_sow),
    .bin_out_bit  (bin_out_bit),
    .bin_out_vld  (bin_out_vld),
    .bin_in_bit   (bin_in_bit),
    .bin_in_vld   (bin_in_vld),
    .bin_in_sow   (bin_in_sow),
    .gray_out_bit (gray_out_bit),
    .gray_out_vld (gray_out_vld)
);

// File: tb/test_serial_gray_codec.sv
module test_serial_gray_codec;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gray_in_bit = 1'b0, gray_in_vld = 1'b0, gray_in_sow = 1'b0;
    logic bin_in_bit  = 1'b0, bin_in_vld  = 1'b0, bin_in_sow  = 1'b0;
    logic bin_out_bit, bin_out_vld, gray_out_bit, gray_out_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // pending expectations for the outputs after the next edge
    bit    p_act = 1'b0;
    logic  p_dv, p_de, p_ev, p_ee;
    string p_dt, p_et;
    logic  last_d = 1'b0, last_e = 1'b0;

    always #5 clk = ~clk;

    serial_gray_codec i_serial_gray_codec (
        .clk          (clk),
        .rst          (rst),
        .gray_in_bit  (gray_in_bit),
        .gray_in_vld  (gray_in_vld),
        .gray_in_sow  (gray_in_sow),
        .bin_out_bit  (bin_out_bit),
        .bin_out_vld  (bin_out_vld),
        .bin_in_bit   (bin_in_bit),
        .bin_in_vld   (bin_in_vld),
        .bin_in_sow   (bin_in_sow),
        .gray_out_bit (gray_out_bit),
        .gray_out_vld (gray_out_vld)
    );

    task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_pending();
        if (p_act) begin
            chk(bin_out_vld  == p_dv, {p_dt, " R2 decode valid"}, bin_out_vld,  p_dv);
            chk(bin_out_bit  == p_de, {p_dt, " decode bit"},      bin_out_bit,  p_de);
            chk(gray_out_vld == p_ev, {p_et, " R2 encode valid"}, gray_out_vld, p_ev);
            chk(gray_out_bit == p_ee, {p_et, " encode bit"},      gray_out_bit, p_ee);
        end
    endtask

    // one cycle: check previous result, then drive new inputs
    task automatic step(input logic dv, input logic db, input logic ds, input logic de, input string dt,
                        input logic ev, input logic eb, input logic es, input logic ee, input string et);
        @(negedge clk);
        check_pending();
        gray_in_vld = dv; gray_in_bit = db; gray_in_sow = ds;
        bin_in_vld  = ev; bin_in_bit  = eb; bin_in_sow  = es;
        p_dv = dv; p_de = dv ? de : last_d; last_d = p_de; p_dt = dt;
        p_ev = ev; p_ee = ev ? ee : last_e; last_e = p_ee; p_et = et;
        p_act = 1'b1;
    endtask

    // binary bit i of a Gray word: XOR of Gray bits from the MSB down to i
    function automatic logic ref_bin(input logic [15:0] g, input int w, input int i);
        logic p = 1'b0;
        for (int k = w - 1; k >= i; k--) p ^= g[k];
        return p;
    endfunction

    // Gray bit i of a binary word
    function automatic logic ref_gray(input logic [15:0] b, input int w, input int i);
        return b[i] ^ ((i < w - 1) ? b[i + 1] : 1'b0);
    endfunction

    // send one word on each enabled channel; gaps put an idle cycle before odd bits
    task automatic run_word(input int w, input logic [15:0] gw, input logic [15:0] bw,
                            input bit gaps, input bit den, input bit een, input string ctx);
        for (int i = w - 1; i >= 0; i--) begin
            if (gaps && (i % 2 == 1) && (i != w - 1))
                // idle cycle with strobe and data high: must be ignored (R7)
                step(1'b0, 1'b1, 1'b1, 1'b0, "R7 idle",
                     1'b0, 1'b1, 1'b1, 1'b0, "R7 idle");
            step(den, den ? gw[i] : 1'b1, den && (i == w - 1), ref_bin(gw, w, i),
                 den ? {ctx, (i == w - 1) ? " R3" : " R4"} : "R8 decode quiet",
                 een, een ? bw[i] : 1'b1, een && (i == w - 1), ref_gray(bw, w, i),
                 een ? {ctx, (i == w - 1) ? " R5" : " R6"} : "R8 encode quiet");
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        chk(bin_out_vld  == 1'b0, "R1 decode valid", bin_out_vld,  1'b0);
        chk(bin_out_bit  == 1'b0, "R1 decode bit",   bin_out_bit,  1'b0);
        chk(gray_out_vld == 1'b0, "R1 encode valid", gray_out_vld, 1'b0);
        chk(gray_out_bit == 1'b0, "R1 encode bit",   gray_out_bit, 1'b0);
        rst = 1'b0;

        // R10: worked example in both directions
        run_word(7, 16'b1001011, 16'b1110010, 1'b0, 1'b1, 1'b1, "R10");
        run_word(7, 16'b1001011, 16'b1110010, 1'b1, 1'b1, 1'b1, "R10 gapped");

        // exhaustive sweep over widths 1..6, back-to-back unless gapped (R9)
        for (int w = 1; w <= 6; w++) begin
            for (int v = 0; v < (1 << w); v++) begin
                logic [15:0] mask = 16'((1 << w) - 1);
                run_word(w, 16'(v), 16'(v * 5 + 3) & mask, (v % 3 == 0), 1'b1, 1'b1,
                         (v % 3 == 0) ? "sweep" : "R9 sweep");
            end
        end

        // R8: each channel alone while the other stays quiet
        run_word(8, 16'hB6, 16'h00, 1'b0, 1'b1, 1'b0, "R8 decode only");
        run_word(8, 16'h00, 16'h5D, 1'b0, 1'b0, 1'b1, "R8 encode only");

        // wider words, 16 bits, back to back
        run_word(16, 16'hA5C3, 16'h3C5A, 1'b0, 1'b1, 1'b1, "R9 wide");
        run_word(16, 16'hFFFF, 16'h8001, 1'b1, 1'b1, 1'b1, "wide gapped");

        step(1'b0, 1'b0, 1'b0, 1'b0, "R7 drain", 1'b0, 1'b0, 1'b0, 1'b0, "R7 drain");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7 drain", 1'b0, 1'b0, 1'b0, 1'b0, "R7 drain");
        @(negedge clk);
        check_pending();
        report();
    end

endmodule